// File: doc/BRIEF.md
# Posted-Interrupt Notification Receiver

This block handles posted interrupts on the processor side for a single virtual processor. Posting sources mark guest vectors ahead of time in a 256-bit pending bitmap held in the posting descriptor, and each post also raises an outstanding-notification flag. The block then watches the stream of physical interrupt vectors arriving at the processor.

When an arriving vector equals the programmed notification vector, the block does not deliver it to the host. Instead it ORs the whole pending bitmap into a 256-bit virtual interrupt-request register, and in the same update it empties the bitmap and drops the flag. No exit is signalled for this path. Any other arriving vector goes out unchanged on a host-delivery port one cycle later. Arbitration among virtual requests and guest acknowledgement belong to other blocks, so the virtual request register only accumulates here.

Top module: `pi_notify_rx`

## Requirements
- R1: After reset, the virtual request register, the pending bitmap, the outstanding flag, the host valid strobe and the host vector are all zero.
- R2: A post with `post_valid` high and vector `post_vec` sets bit `post_vec` of `pend_bits` and sets `pend_flag`; both are visible after the next rising clock edge.
- R3: A strobed vector equal to `notif_vec` makes `virr` equal the bitwise OR of its previous value and the previous `pend_bits`, one edge later.
- R4: The same notification clears `pend_bits` and `pend_flag` in that same edge when no post arrives in the same cycle.
- R5: A post in the same cycle as a notification is not lost. Its bit is left set in `pend_bits` with `pend_flag` set, it is not in the merge of that cycle, and it is merged by the next notification.
- R6: A strobed vector that differs from `notif_vec` appears on `host_vec` with `host_valid` high one edge after the strobe. `pend_bits`, `pend_flag` and `virr` are unchanged by it.
- R7: `host_valid` is low one edge after any cycle that carries no strobe or that carries a strobed notification vector.
- R8: A notification that arrives while the flag is clear and the bitmap is empty still performs the merge, and the merge leaves `virr` unchanged.
- R9: A vector equal to `notif_vec` with `vec_valid` low changes neither the bitmap, the flag nor `virr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vec_valid | input | 1 | Strobe for an arriving physical vector |
| vec_in | input | 8 | Arriving physical vector |
| notif_vec | input | 8 | Programmed notification vector |
| post_valid | input | 1 | Posting source marks a guest vector |
| post_vec | input | 8 | Guest vector being posted |
| virr | output | 256 | Virtual interrupt-request register |
| pend_bits | output | 256 | Pending-request bitmap of the descriptor |
| pend_flag | output | 1 | Outstanding-notification flag of the descriptor |
| host_valid | output | 1 | A vector is being delivered to the host |
| host_vec | output | 8 | Vector delivered to the host |

## Verification
Every result of this block is due exactly one rising edge after the cycle that carries its stimulus. This covers the post into the bitmap, the merge into `virr` with the clearing of bitmap and flag, and the host forward. Nothing takes longer, so no result waits a second cycle. The bench drives inputs on the falling edge, lets the next rising edge consume them, and reads every output on the following falling edge. Its behavioural model is advanced on that same rising edge, which keeps the per-clock comparison and the directed checks aligned to that single edge of latency.

// File: rtl/pi_pkg.sv
// Shared definitions for the posted-interrupt notification receiver.
// Assumes vector width of 8 bits is the default geometry of the processor.
package pi_pkg;
    localparam int VEC_W_DEF = 8;

    // What happens to one arriving physical vector
    typedef enum logic [1:0] {
        DISP_NONE = 2'd0,
        DISP_MERGE = 2'd1,
        DISP_HOST = 2'd2
    } disp_e;
endpackage

// File: rtl/pi_vec_match.sv
// Classifies each strobed physical vector: a match with the notification
// vector requests a merge (combinational), anything else is registered
// onto the host port. Assumes notif_vec is stable while vectors arrive.
module pi_vec_match
    import pi_pkg::*;
#(
    parameter int VEC_W = VEC_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vec_valid,
    input  logic [VEC_W-1:0] vec_in,
    input  logic [VEC_W-1:0] notif_vec,
    output disp_e            disp,
    output logic             host_valid,
    output logic [VEC_W-1:0] host_vec
);
    // Decide the disposition of the current vector
    always_comb begin
        if (!vec_valid)              disp = DISP_NONE;
        else if (vec_in == notif_vec) disp = DISP_MERGE;
        else                         disp = DISP_HOST;
    end

    // Register a non-matching vector onto the host port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_valid <= 1'b0;
            host_vec   <= '0;
        end else begin
            host_valid <= (disp == DISP_HOST);
            if (disp == DISP_HOST) host_vec <= vec_in;
        end
    end

    // R6
    host_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && vec_in != notif_vec) |=> (host_valid && host_vec == $past(vec_in)));
    // R7
    host_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!vec_valid || vec_in == notif_vec) |=> !host_valid);
endmodule

// File: rtl/pi_desc_store.sv
// Holds the posting descriptor: one pending bit per guest vector and the
// outstanding-notification flag. A drain empties both atomically; a post
// in the same cycle survives the drain. Assumes one post per cycle.
module pi_desc_store #(
    parameter int VEC_W = pi_pkg::VEC_W_DEF,
    localparam int NVEC = 1 << VEC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             post_valid,
    input  logic [VEC_W-1:0] post_vec,
    input  logic             drain,
    output logic [NVEC-1:0]  pend_bits,
    output logic             pend_flag
);
    // One flop per guest vector, set by a post, cleared by a drain
    for (genvar i = 0; i < NVEC; i++) begin : g_bit
        logic hit;
        assign hit = post_valid && (post_vec == VEC_W'(i));
        // Update this pending bit
        always_ff @(posedge clk) begin
            if (!rst_n) pend_bits[i] <= 1'b0;
            else        pend_bits[i] <= (pend_bits[i] && !drain) || hit;
        end
    end

    // Outstanding flag: a post sets it, a drain without a post clears it
    always_ff @(posedge clk) begin
        if (!rst_n)          pend_flag <= 1'b0;
        else if (post_valid) pend_flag <= 1'b1;
        else if (drain)      pend_flag <= 1'b0;
    end

    // R2
    post_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        post_valid |=> (pend_bits[$past(post_vec)] && pend_flag));
    // R4
    drain_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drain && !post_valid) |=> (pend_bits == '0 && !pend_flag));
    // R5
    drain_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drain && post_valid) |=> ($countones(pend_bits) == 1 && pend_flag));
    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!drain && !post_valid) |=> ($stable(pend_bits) && $stable(pend_flag)));
endmodule

// File: rtl/pi_virr.sv
// Virtual interrupt-request register. A merge ORs the pending bitmap in;
// nothing else changes it here (acknowledgement lives elsewhere).
module pi_virr #(
    parameter int NVEC = 256
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            merge,
    input  logic [NVEC-1:0] pend_in,
    output logic [NVEC-1:0] virr
);
    // Accumulate pending requests on a merge
    always_ff @(posedge clk) begin
        if (!rst_n)     virr <= '0;
        else if (merge) virr <= virr | pend_in;
    end

    // R3
    merge_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        merge |=> (virr == ($past(virr) | $past(pend_in))));
    // R8
    empty_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (merge && pend_in == '0) |=> $stable(virr));
    // R9
    no_merge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !merge |=> $stable(virr));
endmodule

// File: rtl/pi_notify_rx.sv
// Top of the posted-interrupt notification receiver for one virtual
// processor. Wires the vector classifier, the descriptor store and the
// virtual request register; a matching vector drains the descriptor into
// the register in one edge, others go to the host one edge later.
module pi_notify_rx
    import pi_pkg::*;
#(
    parameter int VEC_W = VEC_W_DEF,
    localparam int NVEC = 1 << VEC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vec_valid,
    input  logic [VEC_W-1:0] vec_in,
    input  logic [VEC_W-1:0] notif_vec,
    input  logic             post_valid,
    input  logic [VEC_W-1:0] post_vec,
    output logic [NVEC-1:0]  virr,
    output logic [NVEC-1:0]  pend_bits,
    output logic             pend_flag,
    output logic             host_valid,
    output logic [VEC_W-1:0] host_vec
);
    disp_e disp;
    logic  merge;

    assign merge = (disp == DISP_MERGE);

    pi_vec_match #(.VEC_W(VEC_W)) u_match (
        .clk(clk), .rst_n(rst_n), .vec_valid(vec_valid), .vec_in(vec_in),
        .notif_vec(notif_vec), .disp(disp),
        .host_valid(host_valid), .host_vec(host_vec)
    );

    pi_desc_store #(.VEC_W(VEC_W)) u_desc (
        .clk(clk), .rst_n(rst_n), .post_valid(post_valid), .post_vec(post_vec),
        .drain(merge), .pend_bits(pend_bits), .pend_flag(pend_flag)
    );

    pi_virr #(.NVEC(NVEC)) u_virr (
        .clk(clk), .rst_n(rst_n), .merge(merge), .pend_in(pend_bits), .virr(virr)
    );

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (virr == '0 && pend_bits == '0 && !pend_flag && !host_valid));
endmodule

// File: tb/pi_notify_rx_test.sv
// Bench: behavioural reference model compared on every falling edge, plus
// directed checks with hand-computed expectations.
module pi_notify_rx_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         vec_valid = 1'b0;
    logic [7:0]   vec_in = '0;
    logic [7:0]   notif_vec = 8'hF0;
    logic         post_valid = 1'b0;
    logic [7:0]   post_vec = '0;
    logic [255:0] virr, pend_bits;
    logic         pend_flag, host_valid;
    logic [7:0]   host_vec;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    // model state
    logic [255:0] m_virr = '0, m_pend = '0;
    logic         m_flag = 1'b0, m_hv = 1'b0;
    logic [7:0]   m_hvec = '0;

    always #10 clk = ~clk;

    pi_notify_rx uut (
        .clk(clk), .rst_n(rst_n), .vec_valid(vec_valid), .vec_in(vec_in),
        .notif_vec(notif_vec), .post_valid(post_valid), .post_vec(post_vec),
        .virr(virr), .pend_bits(pend_bits), .pend_flag(pend_flag),
        .host_valid(host_valid), .host_vec(host_vec)
    );

    task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference model advanced on the edge that consumes the inputs
    always @(posedge clk) begin
        if (!rst_n) begin
            m_virr = '0; m_pend = '0; m_flag = 1'b0; m_hv = 1'b0; m_hvec = '0;
        end else begin
            m_hv = vec_valid && (vec_in != notif_vec);
            if (m_hv) m_hvec = vec_in;
            if (vec_valid && vec_in == notif_vec) begin
                m_virr = m_virr | m_pend;
                m_pend = '0;
                m_flag = 1'b0;
            end
            if (post_valid) begin
                m_pend[post_vec] = 1'b1;
                m_flag = 1'b1;
            end
        end
    end

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R3 virr", virr, m_virr);
            chk("R4 pend_bits", pend_bits, m_pend);
            chk("R4 pend_flag", 256'(pend_flag), 256'(m_flag));
            chk("R6 host_valid", 256'(host_valid), 256'(m_hv));
            chk("R6 host_vec", 256'(host_vec), 256'(m_hvec));
        end
    end

    // Drive one cycle of stimulus, return at the falling edge after it is consumed
    task automatic apply(input logic vv, input logic [7:0] vi, input logic pv, input logic [7:0] pvec);
        vec_valid = vv; vec_in = vi; post_valid = pv; post_vec = pvec;
        @(negedge clk);
        vec_valid = 1'b0; post_valid = 1'b0;
    endtask

    function automatic logic [255:0] bitv(input int idx);
        logic [255:0] v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=done");
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [255:0] exp_v;
        int unsigned seed = 32'h1234_5678;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 virr", virr, '0);
        chk("R1 pend_bits", pend_bits, '0);
        chk("R1 flags", {host_vec, host_valid, pend_flag}, '0);

        // R2 post sets bit and flag
        apply(1'b0, 8'h00, 1'b1, 8'd5);
        chk("R2 bit", pend_bits, bitv(5));
        chk("R2 flag", 256'(pend_flag), 256'd1);
        apply(1'b0, 8'h00, 1'b1, 8'd200);
        apply(1'b0, 8'h00, 1'b1, 8'd0);
        apply(1'b0, 8'h00, 1'b1, 8'd255);
        exp_v = bitv(0) | bitv(5) | bitv(200) | bitv(255);
        chk("R2 bits", pend_bits, exp_v);

        // R6 non-matching vector forwarded, descriptor untouched
        apply(1'b1, 8'h33, 1'b0, 8'd0);
        chk("R6 host_valid", 256'(host_valid), 256'd1);
        chk("R6 host_vec", 256'(host_vec), 256'h33);
        chk("R6 pend_bits", pend_bits, exp_v);
        chk("R6 virr", virr, '0);

        // R7 no strobe: host quiet
        apply(1'b0, 8'h00, 1'b0, 8'd0);
        chk("R7 idle", 256'(host_valid), 256'd0);

        // R9 matching value without strobe
        apply(1'b0, 8'hF0, 1'b0, 8'd0);
        chk("R9 pend_bits", pend_bits, exp_v);
        chk("R9 flag", 256'(pend_flag), 256'd1);
        chk("R9 virr", virr, '0);

        // R3 R4 merge
        apply(1'b1, 8'hF0, 1'b0, 8'd0);
        chk("R3 virr", virr, exp_v);
        chk("R4 pend_bits", pend_bits, '0);
        chk("R4 flag", 256'(pend_flag), 256'd0);
        chk("R7 notif", 256'(host_valid), 256'd0);

        // R8 merge with flag clear and empty bitmap
        apply(1'b1, 8'hF0, 1'b0, 8'd0);
        chk("R8 virr", virr, exp_v);
        chk("R8 flag", 256'(pend_flag), 256'd0);

        // R5 post in the merge cycle survives
        apply(1'b0, 8'h00, 1'b1, 8'd17);
        apply(1'b1, 8'hF0, 1'b1, 8'd99);
        exp_v = exp_v | bitv(17);
        chk("R5 virr", virr, exp_v);
        chk("R5 pend_bits", pend_bits, bitv(99));
        chk("R5 flag", 256'(pend_flag), 256'd1);
        apply(1'b1, 8'hF0, 1'b0, 8'd0);
        exp_v = exp_v | bitv(99);
        chk("R5 next merge", virr, exp_v);

        // Mixed stimulus, checked by the per-clock model
        for (int n = 0; n < 400; n++) begin
            logic [31:0] r;
            seed = seed * 32'd1103515245 + 32'd12345;
            r = seed;
            apply(r[30], (r[3:2] == 2'b00) ? notif_vec : r[15:8], r[29], r[23:16]);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule